// File: doc/BRIEF.md
# Multi-Format Serial PCM Receiver

This block turns a three-wire serial stereo stream (bit clock, word clock, data) into parallel samples. A faster system clock oversamples all three wires. Data and word clock are taken on each rising edge of the bit clock. A 2-bit format input selects one of four framings:

- standard I2S with 24-bit samples
- left-justified framing with 24-bit or 32-bit slots
- right-justified framing with 16-bit samples
- right-justified framing with 24-bit samples

Each stereo pair comes out as two 24-bit words with a single-cycle valid strobe. Both words stay unchanged until the next strobe.

A three-state controller tracks the half-frames:

- **HUNT**: after reset, or after a switch between I2S and the justified formats. It waits for the start of a left half-frame.
- **LEFT**: receives the left half-frame.
- **RIGHT**: receives the right half-frame.

The transitions are:

- *lock*: HUNT to LEFT, when a left half-frame starts.
- *split*: LEFT to RIGHT, at the next word boundary. The left word is held at this point.
- *wrap*: RIGHT to LEFT, at the next boundary. The pair is delivered at this point.
- *relock*: RIGHT to HUNT. This happens instead of *wrap* when the newly selected format uses the other word-clock convention. The pair is still delivered.

The format code is sampled only on *lock* and *wrap*.

Top module: `pcm_serial_rx`

## Requirements
- R1: Format code 00 (I2S): word clock low marks the left channel. The MSB is the data bit on the second bit-clock rising edge after a word-clock transition. The 24 bits starting there form the sample.
- R2: Format code 01 (left-justified): word clock high marks the left channel, and the MSB is on the first rising edge after the transition. The first 24 bits of each half-frame are kept. Any further bits, such as bits 7..0 of a 32-bit slot, are dropped.
- R3: Format code 10 (right-justified 16): word clock high marks left. The last 16 bits before the next word-clock transition form the sample, which appears in output bits 23..8 with bits 7..0 zero. Earlier bits of the half-frame are ignored.
- R4: Format code 11 (right-justified 24): word clock high marks left. The last 24 bits before the next transition form the sample. Earlier bits are ignored.
- R5: valid_o is high for exactly one system clock per stereo pair. It rises when the first bit of the following left half-frame is seen. left_o and right_o change only in the cycle valid_o is high.
- R6: The bit clock, word clock and data are oversampled by clk. Data and word clock must be stable around each bit-clock rising edge. Consecutive bit events are at least two clk cycles apart.
- R7: After reset, no strobe is produced for a partial half-frame or for a half-frame received before the first left half-frame start. The first strobe carries the first complete left/right pair.
- R8: A change of the format code while a frame is in progress does not affect that frame. The new code applies from the next left half-frame start.
- R9: A change between code 00 and a justified code still delivers the pair in progress under the old code. The receiver then returns to hunting, and resumes delivery with the next complete pair in the new format.
- R10: While rst_n is low, valid_o is low and both sample outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word clock (channel select) |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_sel_i | input | 2 | Framing format code |
| left_o | output | 24 | Left sample of the last delivered pair |
| right_o | output | 24 | Right sample of the last delivered pair |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The pair strobe and the reload of the format code fall on the same bit event: the boundary that closes a right half-frame also opens the next left half-frame. The bench provokes this in two ways:

- It changes the format code partway through a left half-frame, and separately partway through a right half-frame, with the new-format stream following directly.
- It crosses between I2S and a justified code, which forces the return to hunting in that same cycle.

It is judged by comparing each delivered pair with values computed from the requirements. The pair in flight must decode under the old code, every later pair under the new one, and the total number of strobes must match the number of complete pairs sent.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_LJ   = 2'b01,
        FMT_RJ16 = 2'b10,
        FMT_RJ24 = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'b00,
        ST_LEFT  = 2'b01,
        ST_RIGHT = 2'b10
    } rx_state_e;

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic bit_ev_o,
    output logic ws_o,
    output logic sd_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sck_p, ws_p, sd_p;
    logic         sck_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p    <= '0;
            ws_p     <= '0;
            sd_p     <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_p    <= {sck_p[TOP-1:0], sck_i};
            ws_p     <= {ws_p[TOP-1:0], ws_i};
            sd_p     <= {sd_p[TOP-1:0], sd_i};
            sck_last <= sck_p[TOP];
        end
    end

    // Word clock and data travel through the same depth as the bit clock,
    // so they are aligned with the detected rising edge.
    assign bit_ev_o = sck_p[TOP] & ~sck_last;
    assign ws_o     = ws_p[TOP];
    assign sd_o     = sd_p[TOP];

    // R6: a rising edge needs a low sample first, so events never abut
    p_event_spaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ev_o |=> !bit_ev_o);

endmodule

// File: rtl/pcm_rx_ctrl.sv
module pcm_rx_ctrl
    import pcm_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_ev_i,
    input  logic       ws_i,
    input  logic [1:0] fmt_sel_i,
    output rx_state_e  st_o,
    output fmt_e       mode_o,
    output logic       hit_o
);
    localparam logic [1:0] PRIME_DONE = 2'd2;

    rx_state_e  st_q, st_d;
    fmt_e       mode_q, eff_fmt, sel_fmt;
    logic       ws_prev, cw, cw_last, left_lvl, is_i2s, same_class;
    logic [1:0] prime_q;

    always_comb begin
        sel_fmt    = fmt_e'(fmt_sel_i);
        eff_fmt    = (st_q == ST_HUNT) ? sel_fmt : mode_q;
        is_i2s     = (eff_fmt == FMT_I2S);
        // I2S boundary lags the word clock by one bit
        cw         = is_i2s ? ws_prev : ws_i;
        left_lvl   = ~is_i2s;
        hit_o      = bit_ev_i && (prime_q == PRIME_DONE) && (cw != cw_last);
        same_class = ((sel_fmt == FMT_I2S) == (mode_q == FMT_I2S));
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HUNT:  if (hit_o && (cw == left_lvl)) st_d = ST_LEFT;   // lock
            ST_LEFT:  if (hit_o) st_d = ST_RIGHT;                      // split
            ST_RIGHT: if (hit_o) st_d = same_class ? ST_LEFT : ST_HUNT; // wrap / relock
            default:  st_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HUNT;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_prev <= 1'b0;
            cw_last <= 1'b0;
            prime_q <= '0;
            mode_q  <= FMT_I2S;
        end else if (bit_ev_i) begin
            ws_prev <= ws_i;
            cw_last <= cw;
            if (st_d == ST_HUNT && st_q != ST_HUNT)
                prime_q <= '0;
            else if (st_q == ST_HUNT && prime_q != PRIME_DONE)
                prime_q <= prime_q + 2'd1;
            if (st_d == ST_LEFT && st_q != ST_LEFT)
                mode_q <= sel_fmt;
        end
    end

    assign st_o   = st_q;
    assign mode_o = mode_q;

    // R8: the format in use is frozen for the whole left half-frame
    p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LEFT) |=> $stable(mode_q));

    // R6: the controller moves only on bit events
    p_state_on_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_ev_i |=> $stable(st_q));

    // R9: hunting only ever ends in a left half-frame
    p_hunt_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HUNT) |=> (st_q == ST_HUNT || st_q == ST_LEFT));

endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
    import pcm_rx_pkg::*;
#(
    parameter int OUT_W   = 24,
    parameter int SHORT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_ev_i,
    input  logic             sd_i,
    input  logic             hit_i,
    input  rx_state_e        st_i,
    input  fmt_e             mode_i,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o
);
    localparam int CNT_W = $clog2(OUT_W + 1);
    localparam int PAD_W = OUT_W - SHORT_W;

    logic [OUT_W-1:0] head_q, tail_q, left_hold, word;
    logic [CNT_W-1:0] cnt_q;

    // head keeps the first OUT_W bits of a half-frame, tail the latest ones
    always_comb begin
        unique case (mode_i)
            FMT_I2S, FMT_LJ: word = head_q;
            FMT_RJ16:        word = {tail_q[SHORT_W-1:0], {PAD_W{1'b0}}};
            FMT_RJ24:        word = tail_q;
            default:         word = head_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q    <= '0;
            tail_q    <= '0;
            cnt_q     <= '0;
            left_hold <= '0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (bit_ev_i) begin
                tail_q <= {tail_q[OUT_W-2:0], sd_i};
                if (hit_i) begin
                    head_q <= {{(OUT_W-1){1'b0}}, sd_i};
                    cnt_q  <= CNT_W'(1);
                    if (st_i == ST_LEFT)
                        left_hold <= word;
                    if (st_i == ST_RIGHT) begin
                        left_o  <= left_hold;
                        right_o <= word;
                        valid_o <= 1'b1;
                    end
                end else if (cnt_q < CNT_W'(OUT_W)) begin
                    head_q <= {head_q[OUT_W-2:0], sd_i};
                    cnt_q  <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // R5: single-cycle strobe
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5: samples held between strobes
    p_hold_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R7: a pair is only released when a right half-frame closes
    p_strobe_from_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(st_i) == ST_RIGHT && $past(bit_ev_i)));

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
    import pcm_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OUT_W       = 24,
    parameter int SHORT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_i,
    input  logic             ws_i,
    input  logic             sd_i,
    input  logic [1:0]       fmt_sel_i,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o
);
    logic      bit_ev, ws_s, sd_s, hit;
    rx_state_e st;
    fmt_e      mode;

    pcm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_i),
        .ws_i     (ws_i),
        .sd_i     (sd_i),
        .bit_ev_o (bit_ev),
        .ws_o     (ws_s),
        .sd_o     (sd_s)
    );

    pcm_rx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_ev_i  (bit_ev),
        .ws_i      (ws_s),
        .fmt_sel_i (fmt_sel_i),
        .st_o      (st),
        .mode_o    (mode),
        .hit_o     (hit)
    );

    pcm_rx_path #(.OUT_W(OUT_W), .SHORT_W(SHORT_W)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_ev_i (bit_ev),
        .sd_i     (sd_s),
        .hit_i    (hit),
        .st_i     (st),
        .mode_i   (mode),
        .left_o   (left_o),
        .right_o  (right_o),
        .valid_o  (valid_o)
    );

endmodule

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [1:0]  fmt_sel = 2'b01;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int total = 0;
    int bad = 0;
    int n_exp = 0;
    int n_got = 0;
    logic        vprev = 1'b0;
    logic [23:0] exp_l [0:63];
    logic [23:0] exp_r [0:63];
    string       exp_tag [0:63];

    always #5 clk = ~clk;

    pcm_serial_rx dut_i (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
        .fmt_sel_i(fmt_sel), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic string fmt_tag(input logic [1:0] f);
        case (f)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic logic left_lvl(input logic [1:0] f);
        return (f != 2'b00);
    endfunction

    function automatic logic [23:0] exp_val(input logic [1:0] f, input logic [31:0] w, input int hl);
        case (f)
            2'b00:   return w[23:0];
            2'b01:   return (hl >= 32) ? w[31:8] : w[23:0];
            2'b10:   return {w[15:0], 8'h00};
            default: return w[23:0];
        endcase
    endfunction

    function automatic logic bit_at(input logic [1:0] f, input logic [31:0] w, input int hl, input int i);
        int dw;
        case (f)
            2'b00: return (i >= 1 && i <= 24) ? w[24-i] : 1'b0;
            2'b01: begin
                dw = (hl >= 32) ? 32 : 24;
                return (i < dw) ? w[dw-1-i] : 1'b0;
            end
            default: begin
                dw = (f == 2'b10) ? 16 : 24;
                // padding ahead of a right-justified word is junk on purpose
                return (i >= hl - dw) ? w[dw-1-(i-(hl-dw))] : ~w[0];
            end
        endcase
    endfunction

    task automatic send_bit(input logic w, input logic d);
        @(negedge clk);
        sck = 1'b0; ws = w; sd = d;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_half(input logic [1:0] f, input logic lvl, input logic [31:0] w,
                             input int hl, input int sw_pos, input logic [1:0] nf);
        for (int i = 0; i < hl; i++) begin
            if (i == sw_pos) fmt_sel = nf;
            send_bit(lvl, bit_at(f, w, hl, i));
        end
    endtask

    // sw_half: -1 none, 0 switch inside left half, 1 inside right half
    task automatic send_frame(input logic [1:0] f, input logic [31:0] l, input logic [31:0] r,
                              input int hl, input int sw_half, input logic [1:0] nf, input string tag);
        exp_l[n_exp]   = exp_val(f, l, hl);
        exp_r[n_exp]   = exp_val(f, r, hl);
        exp_tag[n_exp] = tag;
        n_exp++;
        send_half(f,  left_lvl(f), l, hl, (sw_half == 0) ? 8 : -1, nf);
        send_half(f, ~left_lvl(f), r, hl, (sw_half == 1) ? 8 : -1, nf);
    endtask

    // pair monitor
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            chk("R5 strobe width", {31'b0, vprev}, 32'd0);
            if (n_got >= n_exp) begin
                chk("R7 unexpected strobe", n_got, n_exp - 1);
            end else begin
                chk({exp_tag[n_got], " left"},  {8'b0, left_o},  {8'b0, exp_l[n_got]});
                chk({exp_tag[n_got], " right"}, {8'b0, right_o}, {8'b0, exp_r[n_got]});
            end
            n_got++;
        end
        vprev = valid_o;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] seed_sink;
        seed_sink = $urandom(32'd4711);
        repeat (5) @(negedge clk);
        // R10: reset state
        chk("R10 valid", {31'b0, valid_o}, 0);
        chk("R10 left", {8'b0, left_o}, 0);
        chk("R10 right", {8'b0, right_o}, 0);
        rst_n = 1'b1;

        // R7: partial left half, then a right-level preamble
        send_half(2'b01, 1'b1, $urandom, 10, -1, 2'b01);
        send_half(2'b01, 1'b0, 32'h0, 32, -1, 2'b01);
        chk("R7 no strobe before first pair", n_got, 0);

        // R2: directed 32-bit slot with distinct low byte, then random
        send_frame(2'b01, 32'h7F123456, 32'h80ABCDEF, 32, -1, 2'b01, "R2");
        for (int k = 0; k < 4; k++)
            send_frame(2'b01, $urandom, $urandom, ($urandom % 2) ? 32 : 24, -1, 2'b01, "R2");
        // R8: code changes inside a left half; this pair stays left-justified
        send_frame(2'b01, 32'hA5A5C3C3, 32'h3C3C5A5A, 32, 0, 2'b11, "R2 R8");

        // R4: directed full-scale negative, then random
        send_frame(2'b11, 32'h00800000, 32'h007FFFFF, 32, -1, 2'b11, "R4");
        for (int k = 0; k < 3; k++)
            send_frame(2'b11, $urandom, $urandom, ($urandom % 2) ? 32 : 24, -1, 2'b11, "R4");
        // R8: code changes inside a right half
        send_frame(2'b11, $urandom, $urandom, 32, 1, 2'b10, "R4 R8");

        // R3: exact 16-bit slot and longer slots
        send_frame(2'b10, 32'h00008001, 32'h00007FFF, 16, -1, 2'b10, "R3");
        for (int k = 0; k < 3; k++)
            send_frame(2'b10, $urandom, $urandom, ($urandom % 2) ? 32 : 16, -1, 2'b10, "R3");
        // R9: switch to I2S in the right half; pair still decoded right-justified
        send_frame(2'b10, $urandom, $urandom, 32, 1, 2'b00, "R3 R9");
        send_half(2'b10, 1'b1, 32'h0, 4, -1, 2'b00);
        send_half(2'b00, 1'b1, 32'h0, 32, -1, 2'b00);

        // R1: I2S after re-hunting
        send_frame(2'b00, 32'h00800001, 32'h007FFFFE, 32, -1, 2'b00, "R1 R9");
        for (int k = 0; k < 4; k++)
            send_frame(2'b00, $urandom, $urandom, ($urandom % 2) ? 32 : 25, -1, 2'b00, "R1");
        send_half(2'b00, 1'b0, 32'h0, 4, -1, 2'b00);

        repeat (40) @(negedge clk);
        chk("R5 R7 strobe count", n_got, n_exp);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule